// File: doc/BRIEF.md
# 1-Wire Search Triplet Controller

This block runs one step of a 1-Wire ROM search from one host command. It issues three bit slots to a time-slot sequencer. The first two are read slots: write-1 slots whose line level is sampled. The third is a write slot that carries a branch direction. The block chooses that direction in hardware. It uses the two bits it has just read and a preferred direction that the host supplies in the most significant bit of the command parameter.

The block talks to the sequencer through a slot handshake:
- It raises `slotStart` for one cycle, with the slot value on `slotBit`.
- The sequencer returns the sampled line level with a `slotSampleValid` strobe.
- The sequencer closes the slot with `slotDone`.

Three status bits report the outcome: the first read bit, the second read bit and the direction actually written. A device reset input aborts a running step at once. It clears the status and tells the sequencer to release the line.

Top module: `search_triplet`

## Requirements
- R1: After reset, `busy`, `slotStart`, `slotAbort`, `firstBit`, `secondBit` and `dirTaken` are all 0.
- R2: A `cmdValid` pulse while idle raises `busy` on the next cycle. `slotStart` pulses for exactly one cycle at the start of each of three slots: once after acceptance, and once after each of the first two `slotDone` strobes. `busy` falls in the cycle after the third `slotDone`.
- R3: `slotBit` is 1 for the first and second slots (read slots).
- R4: The preferred direction is bit 7 of `cmdParam`, taken when the command is accepted. Bits 6..0 have no effect.
- R5: When both read bits are 0, the third slot writes the preferred direction.
- R6: Reads 0 then 1 write 0. Reads 1 then 0 write 1.
- R7: Reads 1 then 1 (no device answered) write 1.
- R8: `firstBit` takes the sampled bit at the sample strobe of the first slot. `secondBit` and `dirTaken` take their new values together at the sample strobe of the second slot. Otherwise they hold their values.
- R9: `dirTaken` equals the value driven on `slotBit` in the third slot.
- R10: A `cmdValid` pulse while `busy` is ignored: the running step keeps its preferred direction and slot count.
- R11: `devReset` during a step asserts `slotAbort` in that cycle. On the next cycle, `busy` is 0 and all three status bits are 0.
- R12: `slotSampleValid` and `slotDone` while idle change neither the status bits nor `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devReset | input | 1 | Synchronous device reset; aborts a running step |
| cmdValid | input | 1 | Triplet command strobe |
| cmdParam | input | 8 | Command parameter; bit 7 is the preferred direction |
| slotSampleValid | input | 1 | Sequencer has sampled the line in the current slot |
| slotSampleBit | input | 1 | Sampled line level |
| slotDone | input | 1 | Current slot has ended |
| busy | output | 1 | A search step is in progress |
| slotStart | output | 1 | Start a bit slot (one-cycle pulse) |
| slotBit | output | 1 | Value of the slot being started |
| slotAbort | output | 1 | Release the line and end the current slot |
| firstBit | output | 1 | First read bit |
| secondBit | output | 1 | Second read bit |
| dirTaken | output | 1 | Direction written in the third slot |

## Verification
A wrong slot state shows at the ports within one slot. Either a missing or extra `slotStart` pulse appears, or `busy` falls at the wrong `slotDone`. A wrong preferred-direction or status register shows in the third slot's `slotBit`, or in `dirTaken` on the cycle after the second sample strobe. Because the bench compares every output against its model on every cycle, a divergence is reported on the first cycle it appears.

// File: rtl/search_triplet_pkg.sv
package search_triplet_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READA = 2'd1,
    ST_READB = 2'd2,
    ST_WRITE = 2'd3
  } stepState_t;

  typedef struct packed {
    logic loadPref;
    logic capFirst;
    logic capSecond;
    logic clearAll;
  } dpStrobes_t;
endpackage

// File: rtl/search_triplet_ctrl.sv
module search_triplet_ctrl
  import search_triplet_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       devReset,
  input  logic       cmdValid,
  input  logic       slotSampleValid,
  input  logic       slotDone,
  input  logic       dirIn,
  output logic       busy,
  output logic       slotStart,
  output logic       slotBit,
  output logic       slotAbort,
  output dpStrobes_t strobes
);
  stepState_t state, stateNext;
  logic issue, issueNext;

  always_comb begin
    stateNext = state;
    issueNext = 1'b0;
    unique case (state)
      ST_IDLE:  if (cmdValid) begin stateNext = ST_READA; issueNext = 1'b1; end
      ST_READA: if (slotDone) begin stateNext = ST_READB; issueNext = 1'b1; end
      ST_READB: if (slotDone) begin stateNext = ST_WRITE; issueNext = 1'b1; end
      ST_WRITE: if (slotDone) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
    if (devReset) begin
      stateNext = ST_IDLE;
      issueNext = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      issue <= 1'b0;
    end else begin
      state <= stateNext;
      issue <= issueNext;
    end
  end

  always_comb begin
    strobes.clearAll  = devReset;
    strobes.loadPref  = !devReset && (state == ST_IDLE) && cmdValid;
    strobes.capFirst  = !devReset && (state == ST_READA) && slotSampleValid;
    strobes.capSecond = !devReset && (state == ST_READB) && slotSampleValid;
  end

  assign busy      = (state != ST_IDLE);
  assign slotStart = issue;
  assign slotBit   = (state == ST_WRITE) ? dirIn : 1'b1;
  assign slotAbort = devReset && busy;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |=> !slotStart); // R2
  AST_START_IN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |-> busy); // R2
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    devReset |=> !busy && !slotStart); // R11
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy && !slotDone && !devReset |=> busy); // R10
  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !cmdValid |=> !busy); // R12
endmodule

// File: rtl/search_triplet_dp.sv
module search_triplet_dp
  import search_triplet_pkg::*;
#(
  parameter int ParamWidth = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobes_t            strobes,
  input  logic [ParamWidth-1:0] cmdParam,
  input  logic                  sampleBit,
  output logic                  firstBit,
  output logic                  secondBit,
  output logic                  dirBit
);
  localparam int PrefIdx = ParamWidth - 1;

  logic prefDir;
  logic chosenDir;

  // Any 1 in the reads decides the branch; only 0/0 falls back to the host choice.
  assign chosenDir = (firstBit | sampleBit) ? firstBit : prefDir;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prefDir   <= 1'b0;
      firstBit  <= 1'b0;
      secondBit <= 1'b0;
      dirBit    <= 1'b0;
    end else if (strobes.clearAll) begin
      prefDir   <= 1'b0;
      firstBit  <= 1'b0;
      secondBit <= 1'b0;
      dirBit    <= 1'b0;
    end else begin
      if (strobes.loadPref) prefDir <= cmdParam[PrefIdx];
      if (strobes.capFirst) firstBit <= sampleBit;
      if (strobes.capSecond) begin
        secondBit <= sampleBit;
        dirBit    <= chosenDir;
      end
    end
  end

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> !firstBit && !secondBit && !dirBit); // R11
  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capFirst && !strobes.clearAll |=> $stable(firstBit)); // R8
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capSecond && !strobes.clearAll |=> $stable(dirBit) && $stable(secondBit)); // R8
  AST_NO_DEVICE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capSecond && firstBit && sampleBit |=> dirBit); // R7
endmodule

// File: rtl/search_triplet.sv
module search_triplet
  import search_triplet_pkg::*;
#(
  parameter int ParamWidth = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  devReset,
  input  logic                  cmdValid,
  input  logic [ParamWidth-1:0] cmdParam,
  input  logic                  slotSampleValid,
  input  logic                  slotSampleBit,
  input  logic                  slotDone,
  output logic                  busy,
  output logic                  slotStart,
  output logic                  slotBit,
  output logic                  slotAbort,
  output logic                  firstBit,
  output logic                  secondBit,
  output logic                  dirTaken
);
  dpStrobes_t strobes;

  search_triplet_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .devReset(devReset), .cmdValid(cmdValid),
    .slotSampleValid(slotSampleValid), .slotDone(slotDone), .dirIn(dirTaken),
    .busy(busy), .slotStart(slotStart), .slotBit(slotBit),
    .slotAbort(slotAbort), .strobes(strobes)
  );

  search_triplet_dp #(.ParamWidth(ParamWidth)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdParam(cmdParam),
    .sampleBit(slotSampleBit), .firstBit(firstBit), .secondBit(secondBit),
    .dirBit(dirTaken)
  );
endmodule

// File: tb/test_search_triplet.sv
module test_search_triplet;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic devReset = 1'b0, cmdValid = 1'b0;
  logic [7:0] cmdParam = 8'h00;
  logic slotSampleValid = 1'b0, slotSampleBit = 1'b0, slotDone = 1'b0;
  logic busy, slotStart, slotBit, slotAbort, firstBit, secondBit, dirTaken;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  search_triplet i_search_triplet (
    .clk(clk), .rstN(rstN), .devReset(devReset), .cmdValid(cmdValid),
    .cmdParam(cmdParam), .slotSampleValid(slotSampleValid),
    .slotSampleBit(slotSampleBit), .slotDone(slotDone), .busy(busy),
    .slotStart(slotStart), .slotBit(slotBit), .slotAbort(slotAbort),
    .firstBit(firstBit), .secondBit(secondBit), .dirTaken(dirTaken)
  );

  // Behavioural reference: phase 0 idle, 1..3 = slot number of the step.
  int mPhase = 0;
  bit mIssue = 0, mPref = 0, mFirst = 0, mSecond = 0, mDir = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mIssue = 0; mPref = 0; mFirst = 0; mSecond = 0; mDir = 0;
    end else if (devReset) begin
      mPhase = 0; mIssue = 0; mPref = 0; mFirst = 0; mSecond = 0; mDir = 0;
    end else begin
      mIssue = 0;
      if (mPhase == 0) begin
        if (cmdValid) begin mPhase = 1; mIssue = 1; mPref = cmdParam[7]; end
      end else begin
        if (slotSampleValid && mPhase == 1) mFirst = slotSampleBit;
        if (slotSampleValid && mPhase == 2) begin
          mSecond = slotSampleBit;
          if (mFirst == 1'b0 && slotSampleBit == 1'b0) mDir = mPref;
          else if (mFirst == 1'b0) mDir = 1'b0;
          else mDir = 1'b1;
        end
        if (slotDone) begin
          mPhase = (mPhase == 3) ? 0 : mPhase + 1;
          mIssue = (mPhase != 0);
        end
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Per-cycle comparison, 5 ns before each rising edge.
  always @(negedge clk) begin
    #5;
    if (rstN) begin
      check("R2 busy", busy, mPhase != 0);
      check("R2 slotStart", slotStart, mIssue);
      if (mIssue) check("R3/R9 slotBit", slotBit, (mPhase == 3) ? mDir : 1'b1);
      check("R11 slotAbort", slotAbort, devReset && mPhase != 0);
      check("R8 firstBit", firstBit, mFirst);
      check("R8 secondBit", secondBit, mSecond);
      check("R8/R9 dirTaken", dirTaken, mDir);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic waitStart(output logic bitSeen);
    int n = 0;
    do begin tick(); #5; n++; end while (!slotStart && n < 50);
    bitSeen = slotBit;
  endtask

  task automatic runSlot(input logic sampleVal, output logic bitSeen);
    waitStart(bitSeen);
    tick(); slotSampleValid = 1; slotSampleBit = sampleVal;
    tick(); slotSampleValid = 0;
    tick(); slotDone = 1;
    tick(); slotDone = 0;
  endtask

  task automatic triplet(input logic pref, input logic [6:0] other,
                         input logic r1, input logic r2, input logic expDir,
                         input string tag, input bit extraCmd);
    logic b1, b2, b3;
    tick(); cmdValid = 1; cmdParam = {pref, other};
    tick(); cmdValid = 0;
    #5 check("R2 busy after accept", busy, 1'b1);
    runSlot(r1, b1);
    if (extraCmd) begin
      tick(); cmdValid = 1; cmdParam = {~pref, ~other};
      tick(); cmdValid = 0;
    end
    runSlot(r2, b2);
    runSlot(1'b1, b3);
    #5;
    check("R3 first slot reads", b1, 1'b1);
    check("R3 second slot reads", b2, 1'b1);
    check(tag, b3, expDir);
    check("R9 dirTaken equals written bit", dirTaken, b3);
    check("R8 firstBit", firstBit, r1);
    check("R8 secondBit", secondBit, r2);
    check("R2 busy fell after third slot", busy, 1'b0);
  endtask

  initial begin
    logic bs;
    #5;
    check("R1 busy", busy, 1'b0);
    check("R1 slotStart", slotStart, 1'b0);
    check("R1 dirTaken", dirTaken, 1'b0);
    check("R1 slotAbort", slotAbort, 1'b0);
    repeat (2) tick();
    rstN = 1;
    #5;
    check("R1 firstBit", firstBit, 1'b0);
    check("R1 secondBit", secondBit, 1'b0);

    triplet(1'b1, 7'h00, 1'b0, 1'b0, 1'b1, "R5 0/0 pref 1", 0);
    triplet(1'b0, 7'h7f, 1'b0, 1'b0, 1'b0, "R5 R4 0/0 pref 0, low bits set", 0);
    triplet(1'b1, 7'h2a, 1'b0, 1'b1, 1'b0, "R6 0/1 writes 0", 0);
    triplet(1'b0, 7'h55, 1'b1, 1'b0, 1'b1, "R6 1/0 writes 1", 0);
    triplet(1'b0, 7'h00, 1'b1, 1'b1, 1'b1, "R7 1/1 writes 1", 0);
    triplet(1'b1, 7'h11, 1'b0, 1'b0, 1'b1, "R10 R4 command during step ignored", 1);

    // R12: strobes while idle
    tick(); slotSampleValid = 1; slotSampleBit = 0; slotDone = 1;
    tick(); slotSampleValid = 0; slotDone = 0;
    #5;
    check("R12 idle busy", busy, 1'b0);
    check("R12 idle firstBit kept", firstBit, 1'b0);
    check("R12 idle dirTaken kept", dirTaken, 1'b1);

    // R11: abort in the middle of the second slot
    tick(); cmdValid = 1; cmdParam = 8'h80;
    tick(); cmdValid = 0;
    runSlot(1'b1, bs);
    waitStart(bs);
    tick(); devReset = 1;
    #5 check("R11 slotAbort in reset cycle", slotAbort, 1'b1);
    tick(); devReset = 0;
    #5;
    check("R11 busy after abort", busy, 1'b0);
    check("R11 firstBit cleared", firstBit, 1'b0);
    check("R11 dirTaken cleared", dirTaken, 1'b0);
    check("R11 secondBit cleared", secondBit, 1'b0);

    triplet(1'b0, 7'h00, 1'b0, 1'b0, 1'b0, "R5 after abort", 0);

    repeat (3) tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule